// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses for a single read or write burst. A column command supplies the first column together with the current burst settings: a length code, an ordering select and a flag that turns writes into single-location accesses. After that the block issues one column per enabled clock until the burst completes, is stopped, or is replaced by a newer column command. The block handles sequential wrap and interleaved (XOR) ordering inside the burst window, full-row bursts that wrap with no end, and freezing while clock enable is low.

The output is a valid-qualified stream. It has no ready input. The only way to hold it back is to pull `clk_en` low, which freezes every register, the output included, for as long as it stays low. When `col_valid` is high, `col_addr` carries the current column and `col_last` marks the final column of a burst of fixed length, so that auto-precharge can be scheduled. Burst settings are captured when the command is accepted, so a change in `mode_*` during a burst has no effect on that burst. The column width `CW` is a parameter, 8 or 9 bits.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low until a column command is accepted.
- R2: The `mode_len` codes are 000=1, 001=2, 010=4, 011=8 and 111=full row beats. Every other code gives 1 beat. A fixed-length burst holds `col_valid` for exactly that many enabled cycles and then drops it.
- R3: With `mode_ilv`=0, the low log2(L) bits of each column are (start + beat index) mod L, and the upper bits stay equal to those of the start column.
- R4: With `mode_ilv`=1 and a fixed length L, the low log2(L) bits of each column are start XOR beat index, and the upper bits are unchanged.
- R5: A full-row burst steps sequentially through all 2^CW columns, wraps from the top column to 0 and never ends by itself. `mode_ilv` is ignored in this mode.
- R6: With `mode_wsingle`=1, a write (`cmd_write`=1) is a 1-beat burst. Reads still use `mode_len`.
- R7: A column command is accepted in any enabled cycle, including mid-burst. One enabled cycle later the new start column appears with `col_valid` high. A command takes priority over a stop in the same cycle.
- R8: `burst_stop` in an enabled cycle ends a fixed-length burst, so `col_valid` is low in the next cycle. During a full-row burst it is ignored.
- R9: While `clk_en` is low, `col_valid`, `col_addr` and `col_last` hold their values, and commands and stops are ignored.
- R10: `col_last` is high exactly on the final beat of a fixed-length burst and is never high during a full-row burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved ordering |
| mode_wsingle | input | 1 | 1 = writes are single-beat |
| cmd_start | input | 1 | Column command (read or write) |
| cmd_write | input | 1 | Command is a write |
| cmd_col | input | CW | Start column of the command |
| burst_stop | input | 1 | Terminate the current burst |
| col_valid | output | 1 | Column output valid |
| col_addr | output | CW | Current column |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bound checker covers the temporal rules on every cycle: the freeze under low clock enable, command restart with the new start column, the end of the stream after the last beat or after an honoured stop, the absence of `col_last` in full-row mode, and `col_last` only ever appearing with valid data. The exact column orderings can only be shown by the bench's scenarios, which compare each beat against sequences worked out by hand. Those scenarios cover sequential and XOR order, wrap at the burst and row boundaries, the single-write override, reserved codes, and the ordering of a stop against a restart.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  // Settings captured at command acceptance.
  typedef struct packed {
    logic [1:0] len_log2;   // fixed length = 2**len_log2
    logic       full_page;  // whole-row burst
    logic       interleave; // XOR ordering
  } burst_cfg_t;

endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
  import bcg_pkg::*;
(
  input  logic [2:0] len_code,
  input  logic       ilv,
  input  logic       wsingle,
  input  logic       is_write,
  output burst_cfg_t cfg
);

  always_comb begin
    cfg = '0;
    unique case (len_code)
      LEN_1:    cfg.len_log2 = 2'd0;
      LEN_2:    cfg.len_log2 = 2'd1;
      LEN_4:    cfg.len_log2 = 2'd2;
      LEN_8:    cfg.len_log2 = 2'd3;
      LEN_PAGE: cfg.full_page = 1'b1;
      default:  cfg.len_log2 = 2'd0; // reserved codes act as one beat
    endcase
    // Full-row bursts are always sequential.
    cfg.interleave = ilv & ~cfg.full_page;
    if (is_write && wsingle) begin
      cfg.len_log2   = 2'd0;
      cfg.full_page  = 1'b0;
      cfg.interleave = 1'b0;
    end
  end

endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr
  import bcg_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          cmd_start,
  input  logic [CW-1:0] cmd_col,
  input  burst_cfg_t    cfg_in,
  input  logic          burst_stop,
  output logic          active,
  output logic [CW-1:0] start_col,
  output logic [CW-1:0] beat,
  output logic [CW-1:0] mask,
  output burst_cfg_t    cfg_q,
  output logic          last
);

  localparam logic [CW-1:0] BEAT_ONE = CW'(1);

  logic [CW-1:0] mask_in;

  // Window mask: low len_log2 bits for fixed bursts, every bit for a full row.
  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask_in[i] = cfg_in.full_page | (i < int'(cfg_in.len_log2));
  end

  assign last = active & ~cfg_q.full_page & (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      start_col <= '0;
      beat      <= '0;
      mask      <= '0;
      cfg_q     <= '0;
    end else if (clk_en) begin
      if (cmd_start) begin
        active    <= 1'b1;
        start_col <= cmd_col;
        beat      <= '0;
        mask      <= mask_in;
        cfg_q     <= cfg_in;
      end else if (active) begin
        if (last || (burst_stop && !cfg_q.full_page)) begin
          active <= 1'b0;
        end else begin
          beat <= beat + BEAT_ONE;
        end
      end
    end
  end

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int unsigned CW = 8
) (
  input  logic          interleave,
  input  logic [CW-1:0] start_col,
  input  logic [CW-1:0] beat,
  input  logic [CW-1:0] mask,
  output logic [CW-1:0] addr
);

  logic [CW-1:0] seq_sum;
  logic [CW-1:0] xor_val;

  assign seq_sum = start_col + beat;
  assign xor_val = start_col ^ beat;

  // Bits inside the window follow the ordering; bits outside keep the start.
  for (genvar i = 0; i < CW; i++) begin : g_bit
    assign addr[i] = mask[i] ? (interleave ? xor_val[i] : seq_sum[i])
                             : start_col[i];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic [2:0]    mode_len,
  input  logic          mode_ilv,
  input  logic          mode_wsingle,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic [CW-1:0] cmd_col,
  input  logic          burst_stop,
  output logic          col_valid,
  output logic [CW-1:0] col_addr,
  output logic          col_last
);

  burst_cfg_t    cfg_new;
  burst_cfg_t    cfg_cur;
  logic          active;
  logic [CW-1:0] start_col;
  logic [CW-1:0] beat;
  logic [CW-1:0] mask;
  logic          last;
  logic          cur_full;

  bcg_cfg_decode u_dec (
    .len_code (mode_len),
    .ilv      (mode_ilv),
    .wsingle  (mode_wsingle),
    .is_write (cmd_write),
    .cfg      (cfg_new)
  );

  bcg_beat_ctr #(.CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .cmd_start  (cmd_start),
    .cmd_col    (cmd_col),
    .cfg_in     (cfg_new),
    .burst_stop (burst_stop),
    .active     (active),
    .start_col  (start_col),
    .beat       (beat),
    .mask       (mask),
    .cfg_q      (cfg_cur),
    .last       (last)
  );

  bcg_addr_map #(.CW(CW)) u_map (
    .interleave (cfg_cur.interleave),
    .start_col  (start_col),
    .beat       (beat),
    .mask       (mask),
    .addr       (col_addr)
  );

  assign cur_full  = cfg_cur.full_page;
  assign col_valid = active;
  assign col_last  = last;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          cmd_start,
  input logic [CW-1:0] cmd_col,
  input logic          burst_stop,
  input logic          col_valid,
  input logic [CW-1:0] col_addr,
  input logic          col_last,
  input logic          full_page
);

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(col_valid) && $stable(col_addr) && $stable(col_last)));

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && cmd_start) |=> (col_valid && col_addr == $past(cmd_col)));

  a_r2_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && col_last && !cmd_start) |=> !col_valid);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && burst_stop && !cmd_start && col_valid && !full_page) |=> !col_valid);

  a_r8_page_ignores_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && col_valid && full_page && !cmd_start) |=> col_valid);

  a_r10_no_last_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    full_page |-> !col_last);

  a_r10_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

endmodule

bind burst_col_gen bcg_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en     (clk_en),
  .cmd_start  (cmd_start),
  .cmd_col    (cmd_col),
  .burst_stop (burst_stop),
  .col_valid  (col_valid),
  .col_addr   (col_addr),
  .col_last   (col_last),
  .full_page  (cur_full)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  localparam int CW = 8;
  localparam int NV = 11;

  // Vector layout: len[81:79] ilv[78] wsingle[77] write[76] start[75:68]
  // beats[67:64] expected columns [63:0], beat 0 in the top byte.
  localparam logic [81:0] VT [NV] = '{
    {3'b010, 1'b0, 1'b0, 1'b0, 8'h32, 4'd4, 64'h32333031_00000000}, // R3
    {3'b011, 1'b1, 1'b0, 1'b0, 8'h15, 4'd8, 64'h15141716_11101312}, // R4
    {3'b001, 1'b0, 1'b0, 1'b0, 8'h07, 4'd2, 64'h07060000_00000000}, // R3
    {3'b001, 1'b1, 1'b0, 1'b0, 8'h0A, 4'd2, 64'h0A0B0000_00000000}, // R4
    {3'b000, 1'b0, 1'b0, 1'b0, 8'h44, 4'd1, 64'h44000000_00000000}, // R2
    {3'b011, 1'b0, 1'b0, 1'b0, 8'h7E, 4'd8, 64'h7E7F7879_7A7B7C7D}, // R3
    {3'b010, 1'b1, 1'b0, 1'b0, 8'h03, 4'd4, 64'h03020100_00000000}, // R4
    {3'b011, 1'b0, 1'b1, 1'b1, 8'h20, 4'd1, 64'h20000000_00000000}, // R6
    {3'b010, 1'b0, 1'b1, 1'b0, 8'h21, 4'd4, 64'h21222320_00000000}, // R6
    {3'b100, 1'b0, 1'b0, 1'b0, 8'h55, 4'd1, 64'h55000000_00000000}, // R2
    {3'b010, 1'b0, 1'b0, 1'b1, 8'h2D, 4'd4, 64'h2D2E2F2C_00000000}  // R3
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b1;
  logic [2:0]    mode_len = '0;
  logic          mode_ilv = 1'b0;
  logic          mode_wsingle = 1'b0;
  logic          cmd_start = 1'b0;
  logic          cmd_write = 1'b0;
  logic [CW-1:0] cmd_col = '0;
  logic          burst_stop = 1'b0;
  logic          col_valid;
  logic [CW-1:0] col_addr;
  logic          col_last;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  burst_col_gen #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .mode_len(mode_len), .mode_ilv(mode_ilv), .mode_wsingle(mode_wsingle),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .burst_stop(burst_stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue a command at this negedge; return at the next negedge with beat 0 visible.
  task automatic start_cmd(input logic [2:0] len, input logic ilv, input logic ws,
                           input logic wr, input logic [CW-1:0] col);
    mode_len = len; mode_ilv = ilv; mode_wsingle = ws; cmd_write = wr;
    cmd_col = col; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic expect_beat(input string req, input logic [CW-1:0] a, input logic lst);
    check({req, " valid"}, 32'(col_valid), 32'd1);
    check({req, " addr"}, 32'(col_addr), 32'(a));
    check({req, " last"}, 32'(col_last), 32'(lst));
  endtask

  task automatic run_vec(input int idx);
    logic [81:0] v;
    string req;
    int n;
    v = VT[idx];
    n = int'(v[67:64]);
    if (v[77]) req = "R6";
    else if (v[81:79] == 3'b100 || v[81:79] == 3'b000) req = "R2";
    else if (v[78]) req = "R4";
    else req = "R3";
    start_cmd(v[81:79], v[78], v[77], v[76], v[75:68]);
    for (int k = 0; k < n; k++) begin
      expect_beat($sformatf("%s vec%0d beat%0d", req, idx, k),
                  v[63 - 8*k -: 8], k == n - 1);
      @(negedge clk);
    end
    check($sformatf("R2 vec%0d ends", idx), 32'(col_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid after reset", 32'(col_valid), 32'd0);
    check("R1 last after reset", 32'(col_last), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R5: full row wraps past the top column; R8: stop ignored there
    start_cmd(3'b111, 1'b0, 1'b0, 1'b0, 8'hFE);
    expect_beat("R5 page b0", 8'hFE, 1'b0);
    @(negedge clk); expect_beat("R5 page b1", 8'hFF, 1'b0);
    @(negedge clk); expect_beat("R5 page wrap", 8'h00, 1'b0);
    burst_stop = 1'b1;
    @(negedge clk); burst_stop = 1'b0;
    expect_beat("R8 page stop ignored", 8'h01, 1'b0);
    @(negedge clk); expect_beat("R5 page continues", 8'h02, 1'b0);

    // R7: restart mid-burst with a 4-beat sequential burst
    start_cmd(3'b010, 1'b0, 1'b0, 1'b0, 8'h83);
    expect_beat("R7 restart b0", 8'h83, 1'b0);
    @(negedge clk); expect_beat("R7 restart b1", 8'h80, 1'b0);
    @(negedge clk); expect_beat("R7 restart b2", 8'h81, 1'b0);
    @(negedge clk); expect_beat("R10 restart last", 8'h82, 1'b1);
    @(negedge clk); check("R2 restart ends", 32'(col_valid), 32'd0);

    // R5: interleave select ignored in full-row mode
    start_cmd(3'b111, 1'b1, 1'b0, 1'b0, 8'h05);
    expect_beat("R5 page ilv b0", 8'h05, 1'b0);
    @(negedge clk); expect_beat("R5 page ilv b1", 8'h06, 1'b0);

    // R9: freeze holds output and ignores a command
    start_cmd(3'b011, 1'b0, 1'b0, 1'b0, 8'h10);
    @(negedge clk); expect_beat("R9 pre-freeze", 8'h11, 1'b0);
    clk_en = 1'b0; cmd_col = 8'h99; cmd_start = 1'b1; burst_stop = 1'b1;
    @(negedge clk); expect_beat("R9 frozen 1", 8'h11, 1'b0);
    @(negedge clk); expect_beat("R9 frozen 2", 8'h11, 1'b0);
    cmd_start = 1'b0; burst_stop = 1'b0; clk_en = 1'b1;
    @(negedge clk); expect_beat("R9 resume", 8'h12, 1'b0);

    // R8: stop ends a fixed burst
    start_cmd(3'b011, 1'b0, 1'b0, 1'b0, 8'h40);
    @(negedge clk); expect_beat("R8 before stop", 8'h41, 1'b0);
    burst_stop = 1'b1;
    @(negedge clk); burst_stop = 1'b0;
    check("R8 stopped", 32'(col_valid), 32'd0);

    // R7: command beats stop in the same cycle
    start_cmd(3'b011, 1'b0, 1'b0, 1'b0, 8'h50);
    burst_stop = 1'b1;
    start_cmd(3'b001, 1'b0, 1'b0, 1'b0, 8'h61);
    burst_stop = 1'b0;
    expect_beat("R7 start over stop b0", 8'h61, 1'b0);
    @(negedge clk); expect_beat("R7 start over stop b1", 8'h60, 1'b1);
    @(negedge clk); check("R2 short ends", 32'(col_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule